// File: doc/BRIEF.md
# Tamper Event Sticky Flag Register

This block gathers fault and intrusion indications from five sources and records each one as a sticky status bit. The sources are a battery over-voltage comparator, a battery under-voltage comparator, a core-supply over-voltage comparator and two external tamper sensor pins. Each source has its own enable bit. Each sensor pin also has a polarity bit that selects whether it is wired normally open or normally closed. When a hardware source sets its flag for the first time, the block emits a one-clock destructive-reset request. Downstream logic uses that request to wipe secrets.

All inputs pass through a synchronizer before detection. The flags live in a small register that software can read and write. Writing a 1 sets a flag without raising the reset request, and writing a 0 clears it. An ordinary system reset leaves the flags as they are, so firmware can find out after restart what caused the wipe. Only a brown-out reset clears them.

Top module: `tamper_flag_reg`

## Requirements
- R1: Flag bit 0 (battery high) is set when `en_hibat` is 1 and `cmp_hibat` rises, and `drst_pulse` is raised together with it.
- R2: Flag bit 1 (battery low) is set when `en_lobat` is 1 and `cmp_lobat` rises, and `drst_pulse` is raised together with it.
- R3: Flag bit 2 (core supply high) is set when `en_hicore` is 1 and `cmp_hicore` rises, and `drst_pulse` is raised together with it.
- R4: Sensor n sets flag bit 3+n and raises `drst_pulse`. When `ext_nc[n]`=0 the tamper condition is `ext_pin[n]` high. When `ext_nc[n]`=1 the tamper condition is `ext_pin[n]` low.
- R5: A source whose enable bit is 0 sets no flag and raises no `drst_pulse`, whatever its input does.
- R6: While `sys_rst` is 1, the flags keep their values and `drst_pulse` stays 0.
- R7: `bor_rst` clears every flag to 0 in the next cycle.
- R8: A write (`wr_en`=1) loads flag bits 4:0 from `wr_data[4:0]`, both setting and clearing them, and never raises `drst_pulse`.
- R9: Bits 7:5 of `flags_q` always read 0, even after a write of 1s to them.
- R10: If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R11: A flag and its `drst_pulse` appear on the third rising edge after the input changes. The pulse lasts one cycle. An input held at its tamper level does not fire again. An event on a flag that is already set gives no pulse.
- R12: A tamper condition that is already present when `sys_rst` is released does not fire. It fires only after it has gone away and come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous system reset, active high; flags are kept |
| bor_rst | input | 1 | Synchronous brown-out reset, active high; clears flags |
| cmp_hibat | input | 1 | Battery over-voltage comparator output |
| cmp_lobat | input | 1 | Battery under-voltage comparator output |
| cmp_hicore | input | 1 | Core-supply over-voltage comparator output |
| ext_pin | input | 2 | Raw external tamper sensor pins |
| en_hibat | input | 1 | Enable for the battery-high source |
| en_lobat | input | 1 | Enable for the battery-low source |
| en_hicore | input | 1 | Enable for the core-supply-high source |
| en_ext | input | 2 | Enables for the sensor sources |
| ext_nc | input | 2 | Sensor polarity: 0 normally open, 1 normally closed |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Flag register write data |
| flags_q | output | 8 | Flag register readback |
| drst_pulse | output | 1 | One-cycle destructive-reset request |

## Verification
A change on a hardware input takes two synchronizer edges to reach the detector. The third edge loads the flag and the pulse register, so the bench drives inputs on the falling edge and samples one time unit after the third rising edge. It then samples again one edge later to confirm that the pulse has dropped. A software write takes effect on the first rising edge, and a brown-out reset takes effect on the first edge it is held. Checks that something did not happen use a pulse counter sampled on falling edges over a window of at least six cycles, which is longer than the detection path.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int NUM_SRC   = 5;
  localparam int NUM_EXT   = 2;
  localparam int SRC_HIBAT = 0;
  localparam int SRC_LOBAT = 1;
  localparam int SRC_HICOR = 2;
  localparam int SRC_EXT0  = 3;
endpackage

// File: rtl/tfr_sync.sv
module tfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic bor_rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (bor_rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tfr_detect.sv
module tfr_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic bor_rst,
  input  logic raw_i,
  input  logic enable_i,
  input  logic invert_i,
  output logic event_o
);
  logic synced;
  logic cond;
  logic cond_q;

  tfr_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .bor_rst (bor_rst),
    .d_i     (raw_i),
    .q_o     (synced)
  );

  // Polarity-corrected, enabled tamper condition
  assign cond = (synced ^ invert_i) & enable_i;

  // Held at 1 during any reset so a condition already present cannot fire
  always_ff @(posedge clk) begin
    if (bor_rst || sys_rst) cond_q <= 1'b1;
    else cond_q <= cond;
  end

  assign event_o = cond & ~cond_q & ~sys_rst & ~bor_rst;
endmodule

// File: rtl/tfr_flags.sv
module tfr_flags #(
  parameter int NSRC   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              bor_rst,
  input  logic [NSRC-1:0]   hw_evt_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] flags_o,
  output logic              drst_o
);
  localparam int PAD = DATA_W - NSRC;

  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] sw_next;

  // Software path first; hardware events OR on top so they win
  assign sw_next = wr_en_i ? wr_data_i[NSRC-1:0] : flags;

  always_ff @(posedge clk) begin
    if (bor_rst) begin
      flags  <= '0;
      drst_o <= 1'b0;
    end else if (sys_rst) begin
      drst_o <= 1'b0;
    end else begin
      flags  <= sw_next | hw_evt_i;
      drst_o <= |(hw_evt_i & ~flags);
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:NSRC];
      assign flags_o   = {{PAD{1'b0}}, flags};
    end else begin : g_nopad
      assign flags_o = flags;
    end
  endgenerate
endmodule

// File: rtl/tamper_flag_reg.sv
module tamper_flag_reg
  import tfr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              bor_rst,
  input  logic              cmp_hibat,
  input  logic              cmp_lobat,
  input  logic              cmp_hicore,
  input  logic [1:0]        ext_pin,
  input  logic              en_hibat,
  input  logic              en_lobat,
  input  logic              en_hicore,
  input  logic [1:0]        en_ext,
  input  logic [1:0]        ext_nc,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] flags_q,
  output logic              drst_pulse
);
  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] inv_vec;
  logic [NUM_SRC-1:0] evt_vec;

  assign raw_vec = {ext_pin, cmp_hicore, cmp_lobat, cmp_hibat};
  assign en_vec  = {en_ext, en_hicore, en_lobat, en_hibat};
  assign inv_vec = {ext_nc, {SRC_EXT0{1'b0}}};

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      tfr_detect #(.STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .bor_rst  (bor_rst),
        .raw_i    (raw_vec[s]),
        .enable_i (en_vec[s]),
        .invert_i (inv_vec[s]),
        .event_o  (evt_vec[s])
      );
    end
  endgenerate

  tfr_flags #(.NSRC(NUM_SRC), .DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .sys_rst   (sys_rst),
    .bor_rst   (bor_rst),
    .hw_evt_i  (evt_vec),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .flags_o   (flags_q),
    .drst_o    (drst_pulse)
  );
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk
  import tfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              sys_rst,
  input logic              bor_rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] flags_q,
  input logic              drst_pulse
);
  logic seen = 1'b0;
  always_ff @(posedge clk) if (bor_rst) seen <= 1'b1;

  // R7
  bor_clear_chk: assert property (@(posedge clk) bor_rst |=> (flags_q == '0));

  // R6
  sys_hold_chk: assert property (@(posedge clk) disable iff (bor_rst || !seen)
    sys_rst |=> $stable(flags_q));

  // R6
  sys_quiet_chk: assert property (@(posedge clk) disable iff (bor_rst || !seen)
    sys_rst |=> !drst_pulse);

  // R11
  pulse_flag_chk: assert property (@(posedge clk) disable iff (bor_rst || !seen)
    drst_pulse |-> (flags_q[NUM_SRC-1:0] != '0));

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (bor_rst || !seen)
    (|(flags_q & ~$past(flags_q))) |-> ($past(wr_en) || drst_pulse));
endmodule

bind tamper_flag_reg tfr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .sys_rst    (sys_rst),
  .bor_rst    (bor_rst),
  .wr_en      (wr_en),
  .flags_q    (flags_q),
  .drst_pulse (drst_pulse)
);

// File: tb/tb_tamper_flag_reg.sv
`timescale 1ns/1ps
module tb_tamper_flag_reg;
  logic       clk = 1'b0;
  logic       sys_rst, bor_rst;
  logic       cmp_hibat, cmp_lobat, cmp_hicore;
  logic [1:0] ext_pin, en_ext, ext_nc;
  logic       en_hibat, en_lobat, en_hicore;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] flags_q;
  logic       drst_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  logic [7:0] exp_flags = 8'h00;

  always #2 clk = ~clk;

  tamper_flag_reg dut (
    .clk(clk), .sys_rst(sys_rst), .bor_rst(bor_rst),
    .cmp_hibat(cmp_hibat), .cmp_lobat(cmp_lobat), .cmp_hicore(cmp_hicore),
    .ext_pin(ext_pin), .en_hibat(en_hibat), .en_lobat(en_lobat),
    .en_hicore(en_hicore), .en_ext(en_ext), .ext_nc(ext_nc),
    .wr_en(wr_en), .wr_data(wr_data), .flags_q(flags_q), .drst_pulse(drst_pulse)
  );

  always @(negedge clk) if (drst_pulse) pulse_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Drives source idx to its tamper level (t=1) or idle level (t=0)
  task automatic set_src(input int idx, input logic t);
    case (idx)
      0: cmp_hibat  = t;
      1: cmp_lobat  = t;
      2: cmp_hicore = t;
      default: ext_pin[idx-3] = t ^ ext_nc[idx-3];
    endcase
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1'b0;
    exp_flags = d & 8'h1F;
  endtask

  task automatic fire(input int idx, input string req);
    int p0;
    p0 = pulse_cnt;
    @(negedge clk);
    set_src(idx, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    chk({req, " not early"}, {31'd0, flags_q[idx]}, 32'd0);
    @(posedge clk); #1;
    exp_flags[idx] = 1'b1;
    chk({req, " flag"}, flags_q, exp_flags);
    chk({req, " pulse"}, drst_pulse, 1);
    @(posedge clk); #1;
    chk({req, " R11 one cycle"}, drst_pulse, 0);
    chk({req, " pulse count"}, pulse_cnt - p0, 1);
    @(negedge clk);
    set_src(idx, 1'b0);
    idle(4);
  endtask

  task automatic t_reset();
    chk("R7 reset flags", flags_q, 8'h00);
    chk("R7 reset pulse", drst_pulse, 0);
  endtask

  task automatic t_sources();
    fire(0, "R1"); sw_write(8'h00);
    fire(1, "R2"); sw_write(8'h00);
    fire(2, "R3"); sw_write(8'h00);
    fire(3, "R4 normally open"); sw_write(8'h00);
    fire(4, "R4 normally closed"); sw_write(8'h00);
    chk("R4 cleared", flags_q, 8'h00);
  endtask

  task automatic t_disabled();
    int p0;
    p0 = pulse_cnt;
    @(negedge clk);
    en_hibat = 1'b0; en_ext[1] = 1'b0;
    set_src(0, 1'b1); set_src(4, 1'b1);
    idle(6);
    chk("R5 disabled flags", flags_q, exp_flags);
    chk("R5 disabled pulse", pulse_cnt - p0, 0);
    @(negedge clk);
    set_src(0, 1'b0); set_src(4, 1'b0);
    idle(4);
    @(negedge clk);
    en_hibat = 1'b1; en_ext[1] = 1'b1;
    idle(4);
  endtask

  task automatic t_sticky_sys();
    fire(1, "R6 setup");
    @(negedge clk); sys_rst = 1'b1;
    idle(3);
    chk("R6 during sys_rst", flags_q, exp_flags);
    chk("R6 no pulse in reset", drst_pulse, 0);
    @(negedge clk); sys_rst = 1'b0;
    idle(3);
    chk("R6 after sys_rst", flags_q, exp_flags);
    sw_write(8'h00);
  endtask

  task automatic t_bor();
    sw_write(8'h1F);
    chk("R8 set all", flags_q, 8'h1F);
    @(negedge clk); bor_rst = 1'b1;
    @(posedge clk); #1;
    chk("R7 bor clears", flags_q, 8'h00);
    @(negedge clk); bor_rst = 1'b0;
    exp_flags = 8'h00;
    idle(4);
  endtask

  task automatic t_sw();
    int p0;
    p0 = pulse_cnt;
    sw_write(8'h08);
    chk("R8 write one sets", flags_q, 8'h08);
    sw_write(8'hFF);
    chk("R9 upper bits zero", flags_q, 8'h1F);
    idle(6);
    chk("R8 no pulse from write", pulse_cnt - p0, 0);
    sw_write(8'h10);
    chk("R8 write zero clears", flags_q, 8'h10);
    sw_write(8'h00);
  endtask

  task automatic t_hw_wins();
    @(negedge clk);
    set_src(2, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00;
    @(posedge clk); #1;
    chk("R10 hardware wins", flags_q, 8'h04);
    chk("R10 pulse", drst_pulse, 1);
    @(negedge clk); wr_en = 1'b0;
    exp_flags = 8'h04;
    set_src(2, 1'b0);
    idle(4);
    sw_write(8'h00);
  endtask

  task automatic t_level_hold();
    int p0;
    @(negedge clk); set_src(1, 1'b1);
    idle(4);
    chk("R11 held set", flags_q, 8'h02);
    sw_write(8'h00);
    p0 = pulse_cnt;
    idle(6);
    chk("R11 held no refire", flags_q, 8'h00);
    chk("R11 held no pulse", pulse_cnt - p0, 0);
    @(negedge clk); set_src(1, 1'b0);
    idle(4);
    sw_write(8'h04);
    p0 = pulse_cnt;
    @(negedge clk); set_src(2, 1'b1);
    idle(6);
    chk("R11 already set no pulse", pulse_cnt - p0, 0);
    chk("R11 already set flag", flags_q, 8'h04);
    @(negedge clk); set_src(2, 1'b0);
    idle(4);
    sw_write(8'h00);
  endtask

  task automatic t_reset_present();
    int p0;
    p0 = pulse_cnt;
    @(negedge clk); sys_rst = 1'b1; set_src(3, 1'b1);
    idle(4);
    @(negedge clk); sys_rst = 1'b0;
    idle(6);
    chk("R12 no fire at release", flags_q, 8'h00);
    chk("R12 no pulse at release", pulse_cnt - p0, 0);
    @(negedge clk); set_src(3, 1'b0);
    idle(4);
    fire(3, "R12 refire");
    sw_write(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    sys_rst = 1'b1; bor_rst = 1'b1;
    cmp_hibat = 1'b0; cmp_lobat = 1'b0; cmp_hicore = 1'b0;
    ext_nc = 2'b10; ext_pin = 2'b10;
    en_hibat = 1'b1; en_lobat = 1'b1; en_hicore = 1'b1; en_ext = 2'b11;
    wr_en = 1'b0; wr_data = 8'h00;
    idle(4);
    @(negedge clk); sys_rst = 1'b0; bor_rst = 1'b0;
    idle(4);
    t_reset();
    t_sources();
    t_disabled();
    t_sticky_sys();
    t_bor();
    t_sw();
    t_hw_wins();
    t_level_hold();
    t_reset_present();
    summary();
  end
endmodule